// File: doc/BRIEF.md
# Processor Tick Timer

This block is a cycle-counting tick timer for a processor core. Software reaches it through two registers. The count register increments once per clock. The mode register holds a two-bit operating mode, an interrupt enable, a sticky pending flag and a match period. Every cycle the low bits of the count are compared with the period, and a match sets the pending flag. What the counter does at a match depends on the mode: it returns to zero, it freezes, or it carries on counting.

The interrupt request is the pending flag, gated by the mode register's interrupt enable and by a tick-enable input taken from the core's status register. The pending flag stays set until software writes a 0 to it. An uncleared flag therefore keeps the request asserted. Because the compare also runs while counting is off, a disabled timer whose count equals its period raises the pending flag again on every cycle.

Top module: `tick_timer`

## Requirements
- R1: While reset is asserted, both registers read as zero and `irq_o` is low.
- R2: Address 2'b00 selects the mode register and address 2'b01 selects the count register. The mode register layout is: bits [31:30] mode, bit 29 interrupt enable, bit 28 pending, bits [27:0] period. Reads of addresses 2'b10 and 2'b11 return zero. Writes to those addresses change nothing.
- R3: In mode 2'b00 the count holds its value. After counting is re-enabled, it continues upward from the held value.
- R4: In mode 2'b01, the count becomes zero on the clock that follows a match. With period P, the count repeats every P+1 cycles.
- R5: In mode 2'b10, the count freezes at the period once it matches. The mode field still reads back 2'b10.
- R6: In mode 2'b11, the count increments on every clock, including through a match. It wraps modulo 2^32.
- R7: A match means that count bits [27:0] equal the period, and the compare is evaluated in every mode, including 2'b00. A count that starts above the period gives no match until it wraps through zero and climbs back to the period. Count bits [31:28] are ignored by the compare.
- R8: A write to the count register takes effect at the next clock, even while counting. Counting then continues upward from the written value.
- R9: A match sets the pending bit whether or not interrupts are enabled. Writing 0 to bit 28 clears it, and that clear wins over a match in the same cycle. Writing 1 to bit 28 leaves it unchanged.
- R10: `irq_o` is high exactly when the pending bit, the interrupt enable and `tick_en_i` are all high. It stays high until the pending bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock; the count advances once per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access select |
| we_i | input | 1 | Write strobe, valid with `sel_i` |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data; zero when `sel_i` is low |
| tick_en_i | input | 1 | Tick interrupt enable from the status register |
| irq_o | output | 1 | Tick interrupt request |

## Verification
The assertions assume that a register write lasts exactly one cycle with `sel_i` and `we_i` both high. They also assume that the port never writes the count and mode registers in the same cycle, since there is one address per access. The bench drives every access for exactly one clock, between falling edges, and holds `sel_i` low between accesses. Each mode scenario starts by writing mode 0, then the count, then the new mode, so the pending flag and the count start from known values. The bench treats `tick_en_i` as a level that may change at any time. It changes it only on a falling edge.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_CONT    = 2'b11
  } tt_mode_e;

  localparam logic [1:0] ADDR_MODE  = 2'b00;
  localparam logic [1:0] ADDR_COUNT = 2'b01;

  // Control bit positions, counted down from the top of the mode register
  localparam int MODE_HI_OFS = 1;
  localparam int IE_OFS      = 3;
  localparam int IP_OFS      = 4;
endpackage

// File: rtl/tick_timer_cmp.sv
module tick_timer_cmp #(
  parameter int DATA_W = 32,
  parameter int PER_W  = DATA_W - 4
) (
  input  logic [DATA_W-1:0] count_i,
  input  logic [PER_W-1:0]  period_i,
  output logic              match_o
);
  generate
    if (PER_W < DATA_W) begin : g_slice
      logic [DATA_W-PER_W-1:0] unused_hi;
      assign unused_hi = count_i[DATA_W-1:PER_W];
      assign match_o   = (count_i[PER_W-1:0] == period_i);
    end else begin : g_full
      assign match_o = (count_i == period_i);
    end
  endgenerate
endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tt_mode_e          mode_i,
  input  logic              match_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] count_o
);
  logic [DATA_W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (wr_i) begin
      count_d = wdata_i;
    end else begin
      unique case (mode_i)
        MODE_OFF:     count_d = count_q;
        MODE_RESTART: count_d = match_i ? '0 : count_q + 1'b1;
        MODE_ONESHOT: count_d = match_i ? count_q : count_q + 1'b1;
        MODE_CONT:    count_d = count_q + 1'b1;
        default:      count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_o = count_q;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF && !wr_i) |=> $stable(count_q)); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RESTART && match_i && !wr_i) |=> (count_q == '0)); // R4
  AST_ONESHOT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ONESHOT && match_i && !wr_i) |=> $stable(count_q)); // R5
  AST_CONT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CONT && !wr_i) |=> (count_q == $past(count_q) + 1'b1)); // R6
  AST_SW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (count_q == $past(wdata_i))); // R8
endmodule

// File: rtl/tick_timer_mode.sv
module tick_timer_mode
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PER_W  = DATA_W - 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              match_i,
  output tt_mode_e          mode_o,
  output logic              ie_o,
  output logic              ip_o,
  output logic [PER_W-1:0]  period_o
);
  localparam int MODE_HI = DATA_W - MODE_HI_OFS;
  localparam int IE_BIT  = DATA_W - IE_OFS;
  localparam int IP_BIT  = DATA_W - IP_OFS;

  tt_mode_e          mode_q;
  logic              ie_q, ip_q, ip_d;
  logic [PER_W-1:0]  period_q;
  logic              clr_req;

  assign clr_req = wr_i && !wdata_i[IP_BIT];

  // A written 0 beats a same-cycle match; a written 1 changes nothing
  always_comb begin
    if (clr_req) ip_d = 1'b0;
    else         ip_d = ip_q | match_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_OFF;
      ie_q     <= 1'b0;
      period_q <= '0;
    end else if (wr_i) begin
      mode_q   <= tt_mode_e'(wdata_i[MODE_HI -: 2]);
      ie_q     <= wdata_i[IE_BIT];
      period_q <= wdata_i[PER_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ip_q <= 1'b0;
    else         ip_q <= ip_d;
  end

  assign mode_o   = mode_q;
  assign ie_o     = ie_q;
  assign ip_o     = ip_q;
  assign period_o = period_q;

  AST_IP_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && !clr_req) |=> ip_q); // R9
  AST_IP_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req |=> !ip_q); // R9
  AST_IP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ip_q && !clr_req) |=> ip_q); // R10
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_en_i,
  output logic              irq_o
);
  localparam int PER_W = DATA_W - 4;

  logic              mode_wr, count_wr, match;
  tt_mode_e          mode;
  logic              ie, ip;
  logic [PER_W-1:0]  period;
  logic [DATA_W-1:0] count;

  assign mode_wr  = sel_i && we_i && (addr_i == ADDR_MODE);
  assign count_wr = sel_i && we_i && (addr_i == ADDR_COUNT);

  tick_timer_cmp #(.DATA_W(DATA_W), .PER_W(PER_W)) u_cmp (
    .count_i  (count),
    .period_i (period),
    .match_o  (match)
  );

  tick_timer_count #(.DATA_W(DATA_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .match_i (match),
    .wr_i    (count_wr),
    .wdata_i (wdata_i),
    .count_o (count)
  );

  tick_timer_mode #(.DATA_W(DATA_W), .PER_W(PER_W)) u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (mode_wr),
    .wdata_i  (wdata_i),
    .match_i  (match),
    .mode_o   (mode),
    .ie_o     (ie),
    .ip_o     (ip),
    .period_o (period)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      unique case (addr_i)
        ADDR_MODE:  rdata_o = {mode, ie, ip, period};
        ADDR_COUNT: rdata_o = count;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign irq_o = ip & ie & tick_en_i;

  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !mode_wr && tick_en_i) |=> (irq_o || !tick_en_i)); // R10
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i |-> !irq_o); // R10
  AST_NO_MATCH_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_OFF && !count_wr && !mode_wr && !match && !ip) |=> !ip); // R7
endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        sel, we, tick_en;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  tick_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_en_i(tick_en), .irq_o(irq)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [27:0] period;
    logic [31:0] start;
    logic [15:0] cycles;
    logic [31:0] exp_cnt;
    logic        exp_ip;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 28'h100, 32'h0,        16'h80, 32'h80,       1'b0}, // R6 before match
    '{2'b11, 28'h10,  32'h0,        16'h20, 32'h20,       1'b1}, // R6 through match
    '{2'b10, 28'h10,  32'h0,        16'h30, 32'h10,       1'b1}, // R5 freeze
    '{2'b01, 28'h10,  32'h0,        16'h14, 32'h3,        1'b1}, // R4 20 mod 17
    '{2'b00, 28'h10,  32'h5,        16'h20, 32'h5,        1'b0}, // R3 hold
    '{2'b11, 28'h10,  32'h20,       16'h10, 32'h30,       1'b0}, // R7 start above
    '{2'b10, 28'h8,   32'h20,       16'h10, 32'h30,       1'b0}, // R7 one-shot above
    '{2'b01, 28'h8,   32'hFFFFFFF0, 16'h10, 32'h0,        1'b0}, // R7 wrapped, not yet
    '{2'b01, 28'h8,   32'hFFFFFFF0, 16'h1A, 32'h1,        1'b1}, // R7 wrap then match
    '{2'b11, 28'h8,   32'h10000008, 16'h4,  32'h1000000C, 1'b1}  // R7 upper bits ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] mreg(logic [1:0] m, logic ie, logic ip, logic [27:0] p);
    return {m, ie, ip, p};
  endfunction

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, x;
    rst_ni = 1'b0; sel = 0; we = 0; addr = 0; wdata = 0; tick_en = 0;
    idle(3);
    rd(2'b00, d); check("R1 mode reg in reset", d, 32'h0);
    rd(2'b01, d); check("R1 count in reset", d, 32'h0);
    check("R1 irq in reset", {31'h0, irq}, 32'h0);
    @(negedge clk); rst_ni = 1'b1;

    // Vector table: stop, load count, start mode, run, compare
    for (int i = 0; i < NV; i++) begin
      wr(2'b00, 32'h0);
      wr(2'b01, VECS[i].start);
      wr(2'b00, mreg(VECS[i].mode, 1'b0, 1'b0, VECS[i].period));
      idle(int'(VECS[i].cycles));
      rd(2'b01, d);
      check($sformatf("R4/R5/R6/R7 vector %0d count", i), d, VECS[i].exp_cnt);
      rd(2'b00, d);
      check($sformatf("R9 vector %0d pending", i), {31'h0, d[28]}, {31'h0, VECS[i].exp_ip});
      if (VECS[i].mode == 2'b10)
        check("R5 mode reads back one-shot", {30'h0, d[31:30]}, 32'h2);
    end

    // R3: hold and resume from held value
    wr(2'b00, 32'h0);
    wr(2'b01, 32'h200);
    wr(2'b00, mreg(2'b11, 0, 0, 28'h1000));
    idle(7);
    wr(2'b00, mreg(2'b00, 0, 0, 28'h1000));
    rd(2'b01, x);
    idle(20);
    rd(2'b01, d); check("R3 held while off", d, x);
    wr(2'b00, mreg(2'b11, 0, 0, 28'h1000));
    idle(9);
    rd(2'b01, d); check("R3 resumes from held value", d, x + 32'd9);

    // R8: load while counting
    wr(2'b01, 32'h50);
    idle(5);
    rd(2'b01, d); check("R8 load while counting", d, 32'h55);

    // R7/R9: match while off; clear wins over same-cycle match
    tick_en = 1'b1;
    wr(2'b00, mreg(2'b00, 1, 0, 28'h40));
    wr(2'b01, 32'h40);
    wr(2'b00, mreg(2'b00, 1, 0, 28'h40));
    rd(2'b00, d); check("R9 clear beats match", {31'h0, d[28]}, 32'h0);
    idle(1);
    rd(2'b00, d); check("R7 match while off sets pending", {31'h0, d[28]}, 32'h1);
    check("R10 irq with pending off-mode", {31'h0, irq}, 32'h1);
    rd(2'b01, d); check("R3 count held at period", d, 32'h40);

    // R7: other write order, count first then mode
    wr(2'b01, 32'h41);
    wr(2'b00, mreg(2'b00, 1, 0, 28'h41));
    rd(2'b00, d); check("R9 cleared by write", {31'h0, d[28]}, 32'h0);
    idle(1);
    rd(2'b00, d); check("R7 count-first order matches", {31'h0, d[28]}, 32'h1);

    // R10: gating and stickiness
    tick_en = 1'b0;
    wr(2'b00, 32'h0);
    wr(2'b01, 32'h0);
    wr(2'b00, mreg(2'b11, 1, 0, 28'h10));
    idle(32);
    check("R10 masked by tick enable", {31'h0, irq}, 32'h0);
    rd(2'b00, d); check("R9 pending set while masked", {31'h0, d[28]}, 32'h1);
    @(negedge clk); tick_en = 1'b1; #1;
    check("R10 irq when unmasked", {31'h0, irq}, 32'h1);
    idle(10);
    check("R10 irq stays asserted", {31'h0, irq}, 32'h1);
    wr(2'b00, mreg(2'b11, 1, 1, 28'h10));
    rd(2'b00, d); check("R9 writing 1 leaves pending", {31'h0, d[28]}, 32'h1);
    wr(2'b00, mreg(2'b11, 1, 0, 28'h10));
    check("R10 irq drops after clear", {31'h0, irq}, 32'h0);
    wr(2'b00, mreg(2'b10, 0, 0, 28'h10));
    wr(2'b01, 32'h0);
    idle(32);
    rd(2'b00, d); check("R9 pending without enable", {31'h0, d[28]}, 32'h1);
    check("R10 no irq without enable", {31'h0, irq}, 32'h0);

    // R2: unmapped addresses
    wr(2'b00, 32'h0);
    wr(2'b01, 32'h1234);
    wr(2'b10, 32'hFFFFFFFF);
    wr(2'b11, 32'hFFFFFFFF);
    rd(2'b10, d); check("R2 unmapped reads zero", d, 32'h0);
    rd(2'b00, d); check("R2 mode untouched", d, 32'h0);
    rd(2'b01, d); check("R2 count untouched", d, 32'h1234);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule